// File: doc/BRIEF.md
# Per-Bank Capacity Reconfiguration Controller

This controller governs one cache bank that runs either in a compact configuration, which uses only its SRAM ways, or in an extended configuration, which adds a large set of DRAM ways. It watches the bank's access stream over fixed windows of `INTERVAL` cycles. Within each window it counts accesses and misses, and it records which lines were touched in a usage bitmap with one bit per line. It also keeps a per-line flag that marks a line holding modified data in a way that the next configuration change would remove. In the compact mode those are the two SRAM ways that become tag storage. In the extended mode those are the DRAM ways.

On the last cycle of every window it decides whether to grow, shrink or hold. A grow happens when the miss ratio exceeds a fixed-point threshold. A shrink happens when too few distinct lines were touched. When the mode flips, the controller stalls the bank and walks every line index in turn, one per cycle. It raises a flush strobe for each line whose removable-way data is modified, so the bank can write that line back. The stall drops when the walk ends. Each bank carries its own instance and reconfigures independently of the others.

The controller contains no cache arrays and does not model DRAM timing. The window length must exceed the number of lines, so that a flush walk always ends before the next decision.

Top module: `capReconfigCtrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `modeLarge`, `stall` and `flushValid` are all 0 (compact mode).
- R2: Decisions are taken on every `INTERVAL`-th clock edge after reset is released. The first decision edge is the `INTERVAL`-th edge. A resulting mode change is visible at the outputs right after that edge.
- R3: In compact mode, the bank switches to extended mode when misses·2^`FRAC_BITS` > accesses·`MISS_TH`. Misses and accesses are counted over the whole window, including the decision cycle. A ratio exactly at the threshold does not grow.
- R4: In extended mode, the bank switches to compact mode when the number of distinct lines accessed in the window is below `USE_TH`. A count equal to `USE_TH` holds.
- R5: In extended mode, when the miss condition of R3 also holds, the bank stays extended. Grow takes priority over shrink.
- R6: Every window starts with zero counts and an empty usage bitmap. A usage bit is set by any accepted access, whether it hits or misses.
- R7: After each mode change, `stall` is 1 for exactly `LINES` cycles. During that time `flushLine` takes the values 0, 1, …, `LINES`-1 in successive cycles. Afterwards `stall` returns to 0.
- R8: During the walk, `flushValid` is 1 only for a line whose modified flag is set. The flag is set by an accepted access with `accWrite`=1 and `accSpare`=1. A write with `accSpare`=0 leaves it clear. A flag is cleared once the walk passes its line. Outside a walk, `flushValid` is 0.
- R9: Accesses presented while `stall` is 1 are ignored. They change no count, no usage bit and no modified flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access to the bank occurs this cycle |
| accHit | input | 1 | The access hit (1) or missed (0) |
| accWrite | input | 1 | The access modifies the line |
| accSpare | input | 1 | The accessed way is one that the next reconfiguration removes |
| accLine | input | $clog2(LINES) | Line (set) index of the access |
| modeLarge | output | 1 | 0: compact SRAM-only mode, 1: extended mode with DRAM ways |
| stall | output | 1 | Bank must accept no requests; a flush walk is in progress |
| flushValid | output | 1 | `flushLine` holds modified removable data to write back |
| flushLine | output | $clog2(LINES) | Line index currently visited by the flush walk |

## Verification
A corrupted miss or access count shows up only at the next window boundary, as a wrong mode, or as a missing or spurious stall of exactly `LINES` cycles. A stale usage bit behaves the same way, so each window is followed by a check of the mode and of the stall in the cycle after the decision. A lost or phantom modified flag shows up during the following walk, in the exact cycle whose `flushLine` equals that line. A walk pointer that skips or repeats a line is exposed within one cycle by the sequential `flushLine` check.

// File: rtl/capReconfigPkg.sv
package capReconfigPkg;

  // Strobes that the control side drives into the datapath each cycle
  typedef struct packed {
    logic rollInterval;  // last cycle of the current decision window
    logic startWalk;     // mode flips on this edge; flush walk begins
    logic walking;       // flush walk in progress (bank stalled)
  } cfgStrobe_t;

endpackage

// File: rtl/capReconfigDatapath.sv
module capReconfigDatapath
  import capReconfigPkg::*;
#(
  parameter int LINES     = 64,
  parameter int INTERVAL  = 1024,
  parameter int FRAC_BITS = 4,
  parameter int MISS_TH   = 2,
  parameter int USE_TH    = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cfgStrobe_t               strobe,
  input  logic                     accValid,
  input  logic                     accHit,
  input  logic                     accWrite,
  input  logic                     accSpare,
  input  logic [$clog2(LINES)-1:0] accLine,
  output logic                     missHigh,
  output logic                     usageLow,
  output logic                     walkLast,
  output logic                     flushValid,
  output logic [$clog2(LINES)-1:0] flushLine
);

  localparam int LINE_W = $clog2(LINES);
  localparam int CNT_W  = $clog2(INTERVAL + 1);
  localparam int TH_W   = $clog2(MISS_TH + 1);
  localparam int CMP_W  = CNT_W + FRAC_BITS + TH_W;

  logic [CNT_W-1:0]  accCnt, missCnt, accSum, missSum;
  logic [LINES-1:0]  usageBits, usageSum, touchVec;
  logic [LINES-1:0]  dirtyBits;
  logic [LINE_W-1:0] walkPtr;
  logic              accept;
  logic [CMP_W-1:0]  missScaled, accScaled;

  assign accept = accValid && !strobe.walking;

  // Window totals including the current cycle
  assign accSum  = accCnt + CNT_W'(accept);
  assign missSum = missCnt + CNT_W'(accept && !accHit);

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_touch
      assign touchVec[i] = accept && (accLine == LINE_W'(i));
    end
  endgenerate

  assign usageSum = usageBits | touchVec;

  // Fixed-point ratio compare: misses * 2^FRAC_BITS versus accesses * MISS_TH
  assign missScaled = CMP_W'(missSum) << FRAC_BITS;
  assign accScaled  = CMP_W'(accSum) * CMP_W'(MISS_TH);
  assign missHigh   = missScaled > accScaled;
  assign usageLow   = $countones(usageSum) < USE_TH;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accCnt    <= '0;
      missCnt   <= '0;
      usageBits <= '0;
    end else if (strobe.rollInterval) begin
      accCnt    <= '0;
      missCnt   <= '0;
      usageBits <= '0;
    end else begin
      accCnt    <= accSum;
      missCnt   <= missSum;
      usageBits <= usageSum;
    end
  end

  // Modified-removable flags and the sequential walk pointer
  assign walkLast   = strobe.walking && (walkPtr == LINE_W'(LINES - 1));
  assign flushLine  = walkPtr;
  assign flushValid = strobe.walking && dirtyBits[walkPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirtyBits <= '0;
      walkPtr   <= '0;
    end else begin
      if (accept && accWrite && accSpare) dirtyBits[accLine] <= 1'b1;
      if (strobe.walking) dirtyBits[walkPtr] <= 1'b0;
      if (strobe.startWalk)    walkPtr <= '0;
      else if (strobe.walking) walkPtr <= walkLast ? '0 : walkPtr + 1'b1;
    end
  end

  // R7
  walk_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.walking && $past(strobe.walking)) |-> (walkPtr == LINE_W'($past(walkPtr) + 1'b1)));

  // R6
  window_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.rollInterval) |-> (accCnt == '0 && missCnt == '0 && usageBits == '0));

  // R3
  miss_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    missCnt <= accCnt);

  // R9
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.walking && !strobe.rollInterval) |=> (accCnt == $past(accCnt) && usageBits == $past(usageBits)));

endmodule

// File: rtl/capReconfigControl.sv
module capReconfigControl
  import capReconfigPkg::*;
#(
  parameter int INTERVAL = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       missHigh,
  input  logic       usageLow,
  input  logic       walkLast,
  output cfgStrobe_t strobe,
  output logic       modeLarge,
  output logic       stall
);

  localparam int INT_W = $clog2(INTERVAL);

  logic [INT_W-1:0] intCnt;
  logic             boundary, growNow, shrinkNow, flipNow;

  assign boundary  = (intCnt == INT_W'(INTERVAL - 1));
  assign growNow   = boundary && !modeLarge && missHigh;
  // Grow condition wins: a bank under miss pressure never shrinks
  assign shrinkNow = boundary && modeLarge && usageLow && !missHigh;
  assign flipNow   = growNow || shrinkNow;

  assign strobe.rollInterval = boundary;
  assign strobe.startWalk    = flipNow;
  assign strobe.walking      = stall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intCnt    <= '0;
      modeLarge <= 1'b0;
      stall     <= 1'b0;
    end else begin
      intCnt <= boundary ? '0 : intCnt + 1'b1;
      if (flipNow) begin
        modeLarge <= !modeLarge;
        stall     <= 1'b1;
      end else if (walkLast) begin
        stall <= 1'b0;
      end
    end
  end

  // R2
  mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeLarge != $past(modeLarge)) |-> $past(boundary));

  // R7
  stall_on_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> (modeLarge != $past(modeLarge)));

  // R7
  stall_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> $past(walkLast));

endmodule

// File: rtl/capReconfigCtrl.sv
module capReconfigCtrl
  import capReconfigPkg::*;
#(
  parameter int LINES     = 64,
  parameter int INTERVAL  = 1024,
  parameter int FRAC_BITS = 4,
  parameter int MISS_TH   = 2,
  parameter int USE_TH    = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     accValid,
  input  logic                     accHit,
  input  logic                     accWrite,
  input  logic                     accSpare,
  input  logic [$clog2(LINES)-1:0] accLine,
  output logic                     modeLarge,
  output logic                     stall,
  output logic                     flushValid,
  output logic [$clog2(LINES)-1:0] flushLine
);

  cfgStrobe_t strobe;
  logic       missHigh, usageLow, walkLast;

  capReconfigControl #(.INTERVAL(INTERVAL)) uCtrl (
    .clk(clk), .rstN(rstN),
    .missHigh(missHigh), .usageLow(usageLow), .walkLast(walkLast),
    .strobe(strobe), .modeLarge(modeLarge), .stall(stall)
  );

  capReconfigDatapath #(
    .LINES(LINES), .INTERVAL(INTERVAL), .FRAC_BITS(FRAC_BITS),
    .MISS_TH(MISS_TH), .USE_TH(USE_TH)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .accValid(accValid), .accHit(accHit), .accWrite(accWrite),
    .accSpare(accSpare), .accLine(accLine),
    .missHigh(missHigh), .usageLow(usageLow), .walkLast(walkLast),
    .flushValid(flushValid), .flushLine(flushLine)
  );

  // R8
  flush_in_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> stall);

endmodule

// File: tb/tb_capReconfigCtrl.sv
`timescale 1ns/1ps
module tb_capReconfigCtrl;

  localparam int LINES = 8;
  localparam int INTERVAL = 32;
  localparam int FRAC_BITS = 4;
  localparam int MISS_TH = 4;   // grow when miss ratio > 1/4
  localparam int USE_TH = 3;    // shrink when fewer than 3 lines touched
  localparam int LW = $clog2(LINES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accHit = 1'b0, accWrite = 1'b0, accSpare = 1'b0;
  logic [LW-1:0] accLine = '0;
  logic modeLarge, stall, flushValid;
  logic [LW-1:0] flushLine;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // model state
  bit expMode = 1'b0;
  bit expStall = 1'b0;
  bit [LINES-1:0] expDirty = '0;

  always #2.5 clk = ~clk;

  capReconfigCtrl #(
    .LINES(LINES), .INTERVAL(INTERVAL), .FRAC_BITS(FRAC_BITS),
    .MISS_TH(MISS_TH), .USE_TH(USE_TH)
  ) dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit),
    .accWrite(accWrite), .accSpare(accSpare), .accLine(accLine),
    .modeLarge(modeLarge), .stall(stall), .flushValid(flushValid),
    .flushLine(flushLine)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One window of INTERVAL cycles. Cycles 0..LINES-1 observe any flush walk;
  // accesses start at cycle LINES. Access j uses line j%nLines, misses for j<nMiss,
  // writes for j<nWrite with accSpare=spareW. junk drives accesses during the walk.
  task automatic doInterval(input int nAcc, input int nMiss, input int nLines,
                            input int nWrite, input bit spareW, input bit junk,
                            input string modeReq);
    int accN, missN, usedN;
    bit mHigh, uLow;
    chk(modeLarge == expMode, modeReq, modeLarge, expMode);
    for (int c = 0; c < INTERVAL; c++) begin
      accValid = 1'b0; accHit = 1'b0; accWrite = 1'b0; accSpare = 1'b0; accLine = '0;
      if (c < LINES) begin
        if (expStall) begin
          chk(stall == 1'b1, "R7 stall", stall, 1);
          chk(flushLine == LW'(c), "R7 flushLine", flushLine, c);
          chk(flushValid == expDirty[c], "R8 flushValid", flushValid, expDirty[c]);
          if (junk) begin
            accValid = 1'b1; accHit = 1'b0; accWrite = 1'b1; accSpare = 1'b1;
            accLine = LW'(5);
          end
        end else if (c == 0) begin
          chk(stall == 1'b0, "R7 no stall", stall, 0);
          chk(flushValid == 1'b0, "R8 idle flush", flushValid, 0);
        end
      end else begin
        int j = c - LINES;
        if (c == LINES) chk(stall == 1'b0, "R7 stall end", stall, 0);
        if (j < nAcc) begin
          accValid = 1'b1;
          accHit   = (j >= nMiss);
          accWrite = (j < nWrite);
          accSpare = spareW;
          accLine  = LW'(j % nLines);
        end
      end
      @(negedge clk);
    end
    accValid = 1'b0; accWrite = 1'b0;
    // model update
    if (expStall) expDirty = '0;
    for (int j = 0; j < nAcc; j++)
      if (j < nWrite && spareW) expDirty[j % nLines] = 1'b1;
    accN  = nAcc;
    missN = (nMiss < nAcc) ? nMiss : nAcc;
    usedN = (nAcc < nLines) ? nAcc : nLines;
    mHigh = (missN * (1 << FRAC_BITS)) > (accN * MISS_TH);
    uLow  = usedN < USE_TH;
    expStall = 1'b0;
    if (!expMode && mHigh) begin
      expMode = 1'b1; expStall = 1'b1;
    end else if (expMode && uLow && !mHigh) begin
      expMode = 1'b0; expStall = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(modeLarge == 1'b0, "R1 mode", modeLarge, 0);
    chk(stall == 1'b0, "R1 stall", stall, 0);
    chk(flushValid == 1'b0, "R1 flushValid", flushValid, 0);
    rstN = 1'b1;
    // ratio exactly 1/4 holds compact; spare writes to lines 0..3
    doInterval(8, 2, 8, 4, 1'b1, 1'b0, "R1 mode after reset");
    // ratio 3/8 grows
    doInterval(8, 3, 8, 0, 1'b1, 1'b0, "R6 hold at equal ratio");
    // flush lines 0..3; junk during walk must be ignored; empty window shrinks
    doInterval(0, 0, 8, 0, 1'b1, 1'b1, "R3 grow to extended");
    // walk finds nothing (junk ignored, R9); all-miss grows, dirties lines 0,1
    doInterval(12, 12, 2, 12, 1'b1, 1'b0, "R9 shrink despite junk misses");
    // extended: 2 lines used, no misses -> shrink; non-spare writes stay clean
    doInterval(16, 0, 2, 6, 1'b0, 1'b0, "R3 grow again");
    // compact: grow again
    doInterval(10, 10, 4, 0, 1'b1, 1'b0, "R4 shrink on low usage");
    // extended: low usage and high misses -> stay extended (priority)
    doInterval(10, 10, 1, 0, 1'b1, 1'b0, "R3 grow third time");
    // usage exactly USE_TH holds
    doInterval(16, 1, 3, 0, 1'b1, 1'b0, "R5 grow priority holds extended");
    // usage 2 shrinks
    doInterval(16, 1, 2, 0, 1'b1, 1'b0, "R4 hold at usage threshold");
    doInterval(0, 0, 8, 0, 1'b1, 1'b0, "R4 shrink below threshold");
    doInterval(0, 0, 8, 0, 1'b1, 1'b0, "R2 hold on empty window");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule